// File: doc/BRIEF.md
# Input Capture Timer Channel

A single 16-bit timer channel that watches one external capture pin and works in one of two capture styles. In event-counting style the counter moves by one for every qualifying transition on the pin and stops by itself once it reaches a programmed terminal value. In timestamp style the counter runs freely, optionally slowed by a prescaler, and every qualifying transition copies the current count into a readable stamp register while the counter keeps going.

Software drives the channel through a small synchronous register port. It sets up mode, direction, edge type, prescale, load and terminal values while the channel is stopped, then sets the enable bit. Two sticky status flags, one for "terminal count reached" and one for "timestamp taken", each have a mask bit. The interrupt line is high while any unmasked flag is set. Writing a 1 to a bit of the clear register clears the matching flag.

Register map (word addresses on `addr`): 0 CTRL, 1 RELOAD, 2 TERM, 3 SCALE, 4 IMASK, 5 FLAGS (read), 6 write: FLAGCLR / read: masked FLAGS, 7 STAMP, 8 STAMP_SCALE, 9 COUNT. CTRL bits: [0] enable, [2:1] edge type, [4:3] timer mode, [5] timestamp style, [6] count up, [7] reload defer. Flag and mask bits: [0] terminal count reached, [1] timestamp taken.

Top module: `cap_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: While the enable bit is 1, a CTRL write changes only the enable bit, and writes to TERM and SCALE are ignored; a RELOAD write is ignored unless timestamp style is selected.
- R3: The channel reacts to the pin only when the timer-mode field CTRL[4:3] equals 3; CTRL[5]=0 selects event counting and CTRL[5]=1 selects timestamp style. With any other timer-mode value COUNT stays at its start value.
- R4: CTRL[2:1] picks the qualifying transition: 0 rising, 1 falling, 2 or 3 both. The pin is resynchronised by two flops; a transition is acted on at the third rising clock edge after it is sampled.
- R5: Setting the enable bit (from 0) loads COUNT with RELOAD when CTRL[6]=0 (down) or with 0 when CTRL[6]=1 (up); in event-counting style each qualifying transition then moves COUNT by one in the chosen direction.
- R6: In event-counting style, when COUNT reaches TERM the channel sets FLAGS[0], clears the enable bit and holds COUNT; later transitions do not change COUNT.
- R7: In timestamp style the counter steps once every SCALE+1 clocks; counting down it goes from 0 back to RELOAD, counting up it goes from RELOAD back to 0.
- R8: In timestamp style a qualifying transition copies COUNT into STAMP and the prescaler count into STAMP_SCALE, sets FLAGS[1], and the counter keeps running.
- R9: In timestamp style while enabled, a RELOAD write with CTRL[7]=0 restarts COUNT from the new start value on the next cycle; with CTRL[7]=1 the new value is only used at the next wrap.
- R10: `irq` is 1 exactly when some FLAGS bit and its IMASK bit are both 1; address 6 reads FLAGS AND IMASK.
- R11: Writing FLAGCLR clears each flag whose bit is 1 and leaves flags whose bit is 0; a flag set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| cap_in | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions take for granted that the host never reaches for a terminal value equal to the start value and that `addr`, `wr_en` and `wdata` are known at every clock edge; the stimulus only ever writes TERM values that differ from the start count. They also assume the capture pin holds each level long enough for the synchroniser to see it, so the bench changes `cap_in` on the falling clock edge and keeps each level for at least four cycles, except where two timestamps are placed deliberately. Exact timestamp values are predicted by counting clock edges from the enabling write, so every timestamp scenario runs with no register reads between the enable and the captures.

// File: rtl/cap_pkg.sv
// Package: shared register addresses, field encodings and the control
// field bundle of the capture timer. Assumes a 4-bit word address.
package cap_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 4'd1;
    localparam logic [ADDR_W-1:0] A_TERM   = 4'd2;
    localparam logic [ADDR_W-1:0] A_SCALE  = 4'd3;
    localparam logic [ADDR_W-1:0] A_IMASK  = 4'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd5;
    localparam logic [ADDR_W-1:0] A_FCLR   = 4'd6;
    localparam logic [ADDR_W-1:0] A_STAMP  = 4'd7;
    localparam logic [ADDR_W-1:0] A_STPSC  = 4'd8;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd9;

    localparam logic [1:0] TMODE_CAPTURE = 2'd3;
    localparam logic [1:0] EDGE_RISE     = 2'd0;
    localparam logic [1:0] EDGE_FALL     = 2'd1;

    // Control bits [7:1]; the enable bit [0] is kept separately.
    typedef struct packed {
        logic       defer;
        logic       up;
        logic       timed;
        logic [1:0] tmode;
        logic [1:0] edge_sel;
    } ctrl_t;
endpackage

// File: rtl/cap_sync_edge.sv
// Module: brings the asynchronous pin into the clock domain through a
// flop chain and flags the selected transition for one cycle.
// Assumes the pin holds each level for at least one clock period.
module cap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       evt
);
    import cap_pkg::*;

    logic [STAGES-1:0] chain;
    logic              last;
    logic              rise;
    logic              fall;

    // Shift the pin through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[STAGES-1];
        end
    end

    // Decode the transition type requested by the edge select.
    always_comb begin
        rise = chain[STAGES-1] & ~last;
        fall = ~chain[STAGES-1] & last;
        case (sel)
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            default:   evt = rise | fall;
        endcase
    end
endmodule

// File: rtl/cap_prescaler.sv
// Module: divides the clock for the timestamp counter; emits a tick every
// limit+1 cycles while running. Assumes clr restarts the phase at zero.
module cap_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PRE_W-1:0] limit,
    output logic             tick,
    output logic [PRE_W-1:0] phase
);
    // Advance the phase counter, wrapping at the programmed limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr || !run) begin
            phase <= '0;
        end else if (phase == limit) begin
            phase <= '0;
        end else begin
            phase <= phase + PRE_W'(1);
        end
    end

    // A tick marks the last cycle of each divided period.
    always_comb tick = run && (phase == limit);
endmodule

// File: rtl/cap_core.sv
// Module: the shared counter. In event style it steps per qualified
// transition until it meets the terminal value; in timestamp style it
// steps per prescaler tick with wrap and latches a stamp per transition.
// Assumes load_now has priority over every other update.
module cap_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             timed,
    input  logic             up,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] term,
    input  logic             tick,
    input  logic             evt,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] stamp,
    output logic             hit,
    output logic             cap
);
    logic [CNT_W-1:0] step_val;
    logic [CNT_W-1:0] wrap_val;
    logic             ev_step;

    // Next values for a plain step and for a wrapping free-run step.
    always_comb begin
        step_val = up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
        if (up) begin
            wrap_val = (cnt == reload) ? '0 : step_val;
        end else begin
            wrap_val = (cnt == '0) ? reload : step_val;
        end
        ev_step = active && !timed && evt && (cnt != term);
        hit     = ev_step && (step_val == term);
        cap     = active && timed && evt;
    end

    // Counter update: start/reload, free-run tick, or event step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_now) begin
            cnt <= load_val;
        end else if (active && timed && tick) begin
            cnt <= wrap_val;
        end else if (ev_step) begin
            cnt <= step_val;
        end
    end

    // Timestamp latch on each qualified transition in timestamp style.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp <= '0;
        end else if (cap) begin
            stamp <= cnt;
        end
    end
endmodule

// File: rtl/cap_timer.sv
// Module: top of the capture timer channel. Holds the register file,
// the enable/lock rules and the status flags, and wires the synchroniser,
// prescaler and counter. Assumes CNT_W >= 8 and CNT_W > PRE_W.
module cap_timer #(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [cap_pkg::ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]         wdata,
    output logic [CNT_W-1:0]         rdata,
    input  logic                     cap_in,
    output logic                     irq
);
    import cap_pkg::*;

    localparam int NFLAG = 2;
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t            ctrl;
    logic             en_q;
    logic [CNT_W-1:0] reload_r;
    logic [CNT_W-1:0] term_r;
    logic [PRE_W-1:0] scale_r;
    logic [PRE_W-1:0] stamp_sc;
    logic [NFLAG-1:0] mask_r;
    logic [NFLAG-1:0] flags;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;

    logic             wr_ctrl, wr_reload, wr_fclr;
    logic             active, start, rerun, load_now;
    logic [CNT_W-1:0] load_val;
    logic             evt, tick, hit, cap;
    logic [PRE_W-1:0] phase;
    logic [CNT_W-1:0] cnt, stamp;

    // Write strobes and counter start/restart decisions.
    always_comb begin
        wr_ctrl   = wr_en && (addr == A_CTRL);
        wr_reload = wr_en && (addr == A_RELOAD);
        wr_fclr   = wr_en && (addr == A_FCLR);
        active    = en_q && (ctrl.tmode == TMODE_CAPTURE);
        start     = wr_ctrl && wdata[0] && !en_q;
        rerun     = wr_reload && active && ctrl.timed && !ctrl.defer;
        load_now  = start || rerun;
        if (start) begin
            load_val = wdata[6] ? '0 : reload_r;
        end else begin
            load_val = ctrl.up ? '0 : wdata;
        end
    end

    // Control register: fields locked while enabled; a terminal hit stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            en_q <= 1'b0;
        end else begin
            if (wr_ctrl && !en_q) begin
                ctrl <= ctrl_t'(wdata[CTRL_W:1]);
            end
            if (hit) begin
                en_q <= 1'b0;
            end else if (wr_ctrl) begin
                en_q <= wdata[0];
            end
        end
    end

    // Value registers: reload, terminal, prescale and interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_r <= '0;
            term_r   <= '0;
            scale_r  <= '0;
            mask_r   <= '0;
        end else if (wr_en) begin
            if (addr == A_RELOAD && (!en_q || (active && ctrl.timed))) begin
                reload_r <= wdata;
            end
            if (addr == A_TERM && !en_q) begin
                term_r <= wdata;
            end
            if (addr == A_SCALE && !en_q) begin
                scale_r <= wdata[PRE_W-1:0];
            end
            if (addr == A_IMASK) begin
                mask_r <= wdata[NFLAG-1:0];
            end
        end
    end

    // Sticky status flags: set beats write-one-to-clear, per bit.
    always_comb begin
        set_v = {cap, hit};
        clr_v = wr_fclr ? wdata[NFLAG-1:0] : '0;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        // One sticky flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_v[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_v[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

    // Prescaler phase captured alongside each timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_sc <= '0;
        end else if (cap) begin
            stamp_sc <= phase;
        end
    end

    cap_sync_edge #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_in),
        .sel   (ctrl.edge_sel),
        .evt   (evt)
    );

    cap_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active && ctrl.timed),
        .clr   (load_now),
        .limit (scale_r),
        .tick  (tick),
        .phase (phase)
    );

    cap_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .timed    (ctrl.timed),
        .up       (ctrl.up),
        .load_now (load_now),
        .load_val (load_val),
        .reload   (reload_r),
        .term     (term_r),
        .tick     (tick),
        .evt      (evt),
        .cnt      (cnt),
        .stamp    (stamp),
        .hit      (hit),
        .cap      (cap)
    );

    // Interrupt request from unmasked flags.
    always_comb irq = |(flags & mask_r);

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = CNT_W'({ctrl, en_q});
            A_RELOAD: rdata = reload_r;
            A_TERM:   rdata = term_r;
            A_SCALE:  rdata = CNT_W'(scale_r);
            A_IMASK:  rdata = CNT_W'(mask_r);
            A_FLAGS:  rdata = CNT_W'(flags);
            A_FCLR:   rdata = CNT_W'(flags & mask_r);
            A_STAMP:  rdata = stamp;
            A_STPSC:  rdata = CNT_W'(stamp_sc);
            A_COUNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cap_timer_chk.sv
// Module: property checker bound to cap_timer. Observes ports and the
// signals passed between its sub-blocks; drives nothing.
module cap_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       addr,
    input logic [CNT_W-1:0] wdata,
    input logic             irq,
    input logic             en_q,
    input logic [6:0]       ctrl_bits,
    input logic [1:0]       flags,
    input logic [1:0]       mask_r,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] term_r,
    input logic [CNT_W-1:0] stamp,
    input logic             hit,
    input logic             cap,
    input logic             evt,
    input logic             load_now,
    input logic             timed
);
    // R2: control fields do not move while the channel is enabled.
    a_r2_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && wr_en && addr == 4'd0) |=> $stable(ctrl_bits));

    // R6: reaching the terminal value stops the channel and raises flag 0.
    a_r6_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (!en_q && flags[0] && cnt == $past(term_r)));

    // R6: a stopped event-style counter is frozen unless reloaded.
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !load_now) |=> $stable(cnt));

    // R5: in event style the counter only moves on a qualified transition.
    a_r5_step_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!timed && !evt && !load_now) |=> $stable(cnt));

    // R8: a capture latches the count seen in its own cycle.
    a_r8_stamp_value: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (stamp == $past(cnt) && flags[1]));

    // R11: the timestamp flag stays set until a clear with bit 1 high.
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(wr_en && addr == 4'd6 && wdata[1])) |=> flags[1]);

    // R10: with every mask bit low the interrupt line stays low.
    a_r10_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_r == 2'b00) |-> !irq);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq       (irq),
    .en_q      (en_q),
    .ctrl_bits (ctrl),
    .flags     (flags),
    .mask_r    (mask_r),
    .cnt       (cnt),
    .term_r    (term_r),
    .stamp     (stamp),
    .hit       (hit),
    .cap       (cap),
    .evt       (evt),
    .load_now  (load_now),
    .timed     (ctrl.timed)
);

// File: tb/tb_cap_timer.sv
// Scoreboard bench: the driver queues expected register/irq values and a
// monitor on the falling edge reads and compares them in order.
module tb_cap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        cap_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [4:0]  sel;   // 0..15 register address, 31 = irq pin
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    cap_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .irq(irq)
    );

    // Monitor: pop, read and compare one queued expectation per cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb[0];
                if (it.sel == 5'd31) begin
                    #1 act = {15'd0, irq};
                end else begin
                    addr = it.sel[3:0];
                    #1 act = rdata;
                end
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
                end
                void'(sb.pop_front());
            end
        end
    end

    task automatic expect_val(input logic [4:0] sel, input logic [15:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    // Drives at the current falling edge, returns at the next one.
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        cap_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic settle_low();
        @(negedge clk); cap_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_val(5'd0, 16'd0, "R1 ctrl");
        expect_val(5'd5, 16'd0, "R1 flags");
        expect_val(5'd9, 16'd0, "R1 count");
        expect_val(5'd31, 16'd0, "R1 irq");

        // R3 timer mode other than 3: pin ignored
        wr(4'd1, 16'd7);
        wr(4'd0, 16'h0001);
        pulse();
        expect_val(5'd9, 16'd7, "R3 idle mode count");
        wr(4'd0, 16'h0000);

        // R5/R6 event style, counting down, rising edges
        wr(4'd1, 16'd5);
        wr(4'd2, 16'd2);
        wr(4'd4, 16'd1);
        wr(4'd0, 16'h0019);
        expect_val(5'd9, 16'd5, "R5 start from reload");
        pulse();
        expect_val(5'd9, 16'd4, "R5 one rising edge");
        // R2 lock while enabled
        wr(4'd2, 16'd0);
        wr(4'd1, 16'd9);
        wr(4'd0, 16'h0059);
        expect_val(5'd2, 16'd2, "R2 term locked");
        expect_val(5'd1, 16'd5, "R2 reload locked");
        expect_val(5'd0, 16'h0019, "R2 ctrl locked");
        pulse();
        pulse();
        expect_val(5'd9, 16'd2, "R6 count at term");
        expect_val(5'd5, 16'd1, "R6 flag set");
        expect_val(5'd31, 16'd1, "R10 irq high");
        expect_val(5'd0, 16'h0018, "R6 enable cleared");
        pulse();
        expect_val(5'd9, 16'd2, "R6 halted ignores edge");
        wr(4'd6, 16'd2);
        expect_val(5'd5, 16'd1, "R11 zero bit no effect");
        wr(4'd6, 16'd1);
        expect_val(5'd5, 16'd0, "R11 cleared");
        expect_val(5'd31, 16'd0, "R10 irq low");

        // R4 falling edges, counting up
        wr(4'd2, 16'd3);
        wr(4'd0, 16'h005B);
        pulse();
        pulse();
        expect_val(5'd9, 16'd2, "R4 falling edges");
        pulse();
        expect_val(5'd5, 16'd1, "R6 up term reached");
        wr(4'd4, 16'd0);
        expect_val(5'd31, 16'd0, "R10 masked flag");
        wr(4'd6, 16'd3);

        // R4 both edges
        wr(4'd2, 16'd4);
        wr(4'd0, 16'h005D);
        pulse();
        expect_val(5'd9, 16'd2, "R4 both edges");
        pulse();
        expect_val(5'd9, 16'd4, "R4 both edges term");
        wr(4'd6, 16'd3);

        // R8 timestamp style, down, no prescale; counter keeps running
        wr(4'd3, 16'd0);
        wr(4'd1, 16'd1000);
        wr(4'd0, 16'h0039);
        repeat (10) @(negedge clk); cap_in = 1'b1;
        repeat (4)  @(negedge clk); cap_in = 1'b0;
        repeat (6)  @(negedge clk); cap_in = 1'b1;
        repeat (4)  @(negedge clk);
        expect_val(5'd7, 16'd978, "R8 second stamp");
        expect_val(5'd5, 16'd2, "R8 capture flag");
        settle_low();
        wr(4'd0, 16'h0000);

        // R7 prescale by 3
        wr(4'd3, 16'd2);
        wr(4'd0, 16'h0039);
        repeat (11) @(negedge clk); cap_in = 1'b1;
        repeat (4)  @(negedge clk);
        expect_val(5'd7, 16'd996, "R7 prescaled stamp");
        expect_val(5'd8, 16'd1, "R8 prescale phase stamp");
        settle_low();
        wr(4'd0, 16'h0000);

        // R9 immediate reload
        wr(4'd3, 16'd0);
        wr(4'd0, 16'h0039);
        repeat (5) @(negedge clk);
        wr(4'd1, 16'd500);
        repeat (4) @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        expect_val(5'd7, 16'd494, "R9 immediate reload");
        settle_low();
        wr(4'd0, 16'h0000);

        // R9 deferred reload, R7 down wrap
        wr(4'd1, 16'd10);
        wr(4'd0, 16'h00B9);
        repeat (2) @(negedge clk);
        wr(4'd1, 16'd50);
        repeat (17) @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        expect_val(5'd7, 16'd39, "R9 deferred reload at wrap");
        expect_val(5'd1, 16'd50, "R9 reload value");
        settle_low();
        wr(4'd0, 16'h0000);

        // R7 counting up
        wr(4'd1, 16'd1000);
        wr(4'd0, 16'h0079);
        repeat (7) @(negedge clk); cap_in = 1'b1;
        repeat (4) @(negedge clk);
        expect_val(5'd7, 16'd9, "R7 up stamp");
        settle_low();

        // R10 mask, R11 set beats clear
        wr(4'd4, 16'd2);
        expect_val(5'd31, 16'd1, "R10 irq from capture flag");
        expect_val(5'd6, 16'd2, "R10 masked read");
        wr(4'd6, 16'd2);
        expect_val(5'd5, 16'd0, "R11 capture flag cleared");
        @(negedge clk); cap_in = 1'b1;
        repeat (2) @(negedge clk);
        wr(4'd6, 16'd2);
        expect_val(5'd5, 16'd2, "R11 set wins over clear");
        wr(4'd6, 16'd2);
        expect_val(5'd31, 16'd0, "R11 irq after clear");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule